// File: doc/BRIEF.md
# Serial Memory Status and Write-Permission Guard

This block holds the configuration and status state of a serial memory and makes every decision about whether a write may proceed. It keeps a write-enable latch, a two-bit protection level, a lock-enable bit and a busy indication, and presents them as one status byte for the read-status path. A command decoder feeds it single-cycle pulses for the enable, disable and status-write commands, together with the chip-select level. The block also watches the external write-protect pin and the start address of a pending array write.

A status write is captured into a pending holding register while the chip select is low, and it takes effect in the cycle the block first sees chip select high. Taking effect clears the write-enable latch. If the hardware lock engages while chip select is still low, the pending value is discarded. Array writes are granted per start address against the protected region, which always sits at the top of the address space. A granted launch clears the write-enable latch. The configuration registers stand in for non-volatile cells and are cleared only by the power-up reset.

Top module: `status_guard`

## Requirements
- R1: After reset the status byte reads 0x00 and `stat_wr_ok_o`, `arr_wr_ok_o` and `arr_launch_o` are all 0.
- R2: Status bit 0 follows `busy_i`. While `busy_i` is 1, the enable and disable commands and status-write bytes are ignored, and `arr_wr_ok_o` is 0.
- R3: Status bit 1 is the write-enable latch. `wren_i` sets it and `wrdi_i` clears it; when both arrive in the same cycle, `wrdi_i` wins. It is also cleared when a status write takes effect and when an array write is launched.
- R4: A status write alters only bits 2, 3 (protection level, bit 2 low) and 7 (lock enable). Bits 4 to 6 always read 0. The value takes effect at the first clock edge with `cs_n` high after a byte was captured, and the configuration changes at no other time.
- R5: A status-write byte is captured only when `stat_wr_ok_o` is 1. That output is 1 when the latch is 1, `busy_i` is 0 and the hardware lock is off. The hardware lock is on exactly when `wp_n` is 0 and status bit 7 is 1.
- R6: A captured status write is discarded if the hardware lock is on during any cycle in which `cs_n` is 0. At the edge where `cs_n` is first seen high, the write takes effect whatever the level of `wp_n`.
- R7: Protection level 00 protects nothing, 01 protects addresses whose two top bits are 11, 10 protects addresses whose top bit is 1, and 11 protects every address.
- R8: `arr_wr_ok_o` is 1 when the latch is 1, `busy_i` is 0 and `arr_addr_i` is outside the protected region. This holds whether or not the hardware lock is on. A blocked start leaves the latch unchanged.
- R9: `arr_launch_o` is 1 in the cycle `arr_start_i` is 1 while `arr_wr_ok_o` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| cs_n | input | 1 | Chip-select level, low while a command frame is open |
| wp_n | input | 1 | Write-protect pin, low requests the hardware lock |
| busy_i | input | 1 | Internal write cycle in progress |
| wren_i | input | 1 | Write-enable command pulse |
| wrdi_i | input | 1 | Write-disable command pulse |
| stat_wr_i | input | 1 | Status-write data byte valid pulse |
| stat_data_i | input | 8 | Status-write data byte |
| arr_addr_i | input | ADDR_W | Start address of the array write being requested |
| arr_start_i | input | 1 | Request to launch an array write cycle |
| status_o | output | 8 | Status byte for the read-status path |
| stat_wr_ok_o | output | 1 | A status-write byte would be accepted now |
| arr_wr_ok_o | output | 1 | An array write at `arr_addr_i` would be accepted now |
| arr_launch_o | output | 1 | Array write cycle granted this cycle |

## Verification
On every cycle the assertions check four things. The latch rises only after an enable pulse and never rises while busy. The lock always holds off status writes, and full protection always holds off array writes. A launch is always followed by a cleared latch, and the configuration bits change only one cycle after a chip-select rise. The bench scenarios show the rest. They show which bits a status write takes and how each protection level splits the address space. They show that a pending write is discarded when the pin drops while chip select is low, but survives when the pin drops at the moment chip select rises. They also show the priority of disable over enable, and that a mid-run reset clears the configuration.

// File: rtl/sg_pkg.sv
// Shared definitions for the status guard: status bit positions and the
// protection-level encoding. Assumes an 8-bit status byte.
package sg_pkg;
    localparam int STAT_W   = 8;
    localparam int BIT_BUSY = 0;
    localparam int BIT_WEL  = 1;
    localparam int BIT_LVL0 = 2;
    localparam int BIT_LVL1 = 3;
    localparam int BIT_LOCK = 7;

    typedef enum logic [1:0] {
        PROT_NONE    = 2'b00,
        PROT_QUARTER = 2'b01,
        PROT_HALF    = 2'b10,
        PROT_ALL     = 2'b11
    } prot_e;
endpackage

// File: rtl/sg_region_guard.sv
// Decides whether an address falls inside the protected top region.
// Assumes the protected fractions are aligned to the top of the space, so
// only the upper address bits matter. ADDR_W must be at least 2.
module sg_region_guard #(
    parameter int ADDR_W = 14
) (
    input  sg_pkg::prot_e      level_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic               in_prot_o
);
    localparam int TOP = ADDR_W - 1;

    logic top_half;
    logic top_quarter;

    generate
        if (ADDR_W >= 2) begin : g_wide
            // Extract the two region-selecting address bits.
            always_comb begin
                top_half    = addr_i[TOP];
                top_quarter = addr_i[TOP] & addr_i[TOP-1];
            end
        end else begin : g_narrow
            // A one-bit space has no quarter; treat the top half as the quarter.
            always_comb begin
                top_half    = addr_i[TOP];
                top_quarter = addr_i[TOP];
            end
        end
    endgenerate

    // Map the protection level onto the address region.
    always_comb begin
        unique case (level_i)
            sg_pkg::PROT_NONE:    in_prot_o = 1'b0;
            sg_pkg::PROT_QUARTER: in_prot_o = top_quarter;
            sg_pkg::PROT_HALF:    in_prot_o = top_half;
            default:              in_prot_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/sg_pending_cfg.sv
// Holds a status-write byte between capture and chip-select rise.
// Assumes the caller gates capture with the status-write permission and
// supplies a one-cycle chip-select rise pulse.
module sg_pending_cfg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture_i,
    input  logic [W-1:0] data_i,
    input  logic         abort_i,
    input  logic         cs_rise_i,
    output logic         commit_o,
    output logic [W-1:0] data_o
);
    logic pend_q;

    // Fire a commit when chip select rises with a byte held.
    always_comb commit_o = pend_q & cs_rise_i;

    // Track the pending byte: commit and abort drop it, capture loads it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            data_o <= '0;
        end else if (commit_o || abort_i) begin
            pend_q <= 1'b0;
        end else if (capture_i) begin
            pend_q <= 1'b1;
            data_o <= data_i;
        end
    end
endmodule

// File: rtl/sg_enable_latch.sv
// Write-enable latch. Assumes the clear events (commit, launch) are
// produced outside and may arrive while busy; commands are ignored while busy.
module sg_enable_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic set_i,
    input  logic clr_cmd_i,
    input  logic clr_evt_i,
    output logic wel_o
);
    // Update the latch: events clear, disable beats enable, busy freezes commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_o <= 1'b0;
        end else if (clr_evt_i) begin
            wel_o <= 1'b0;
        end else if (!busy_i) begin
            if (clr_cmd_i)
                wel_o <= 1'b0;
            else if (set_i)
                wel_o <= 1'b1;
        end
    end
endmodule

// File: rtl/status_guard.sv
// Top of the status and write-permission guard. Holds the protection level
// and lock-enable bit (stand-ins for non-volatile cells, cleared only by
// reset), assembles the status byte and grants array and status writes.
// Assumes command inputs are single-cycle pulses synchronous to clk.
module status_guard #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wp_n,
    input  logic              busy_i,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              stat_wr_i,
    input  logic [7:0]        stat_data_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    input  logic              arr_start_i,
    output logic [7:0]        status_o,
    output logic              stat_wr_ok_o,
    output logic              arr_wr_ok_o,
    output logic              arr_launch_o
);
    import sg_pkg::*;

    prot_e       level_q;
    logic        lock_en_q;
    logic        cs_n_q;
    logic        wel;
    logic        hw_lock;
    logic        cs_rise;
    logic        in_prot;
    logic        commit;
    logic [7:0]  pend_data;

    // Derive the hardware lock and the chip-select rise.
    always_comb begin
        hw_lock = ~wp_n & lock_en_q;
        cs_rise = cs_n & ~cs_n_q;
    end

    // Grant decisions for status and array writes.
    always_comb begin
        stat_wr_ok_o = wel & ~busy_i & ~hw_lock;
        arr_wr_ok_o  = wel & ~busy_i & ~in_prot;
        arr_launch_o = arr_start_i & arr_wr_ok_o;
    end

    // Assemble the status byte; unused bits read zero.
    always_comb begin
        status_o           = '0;
        status_o[BIT_BUSY] = busy_i;
        status_o[BIT_WEL]  = wel;
        status_o[BIT_LVL0] = level_q[0];
        status_o[BIT_LVL1] = level_q[1];
        status_o[BIT_LOCK] = lock_en_q;
    end

    // Remember the previous chip-select level to find its rise.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_n_q <= 1'b1;
        else        cs_n_q <= cs_n;
    end

    // Load the writable configuration bits when a status write takes effect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q   <= PROT_NONE;
            lock_en_q <= 1'b0;
        end else if (commit) begin
            level_q   <= prot_e'({pend_data[BIT_LVL1], pend_data[BIT_LVL0]});
            lock_en_q <= pend_data[BIT_LOCK];
        end
    end

    sg_region_guard #(.ADDR_W(ADDR_W)) u_region (
        .level_i   (level_q),
        .addr_i    (arr_addr_i),
        .in_prot_o (in_prot)
    );

    sg_pending_cfg #(.W(STAT_W)) u_pending (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (stat_wr_i & stat_wr_ok_o),
        .data_i    (stat_data_i),
        .abort_i   (hw_lock & ~cs_n),
        .cs_rise_i (cs_rise),
        .commit_o  (commit),
        .data_o    (pend_data)
    );

    sg_enable_latch u_wel (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy_i    (busy_i),
        .set_i     (wren_i),
        .clr_cmd_i (wrdi_i),
        .clr_evt_i (commit | arr_launch_o),
        .wel_o     (wel)
    );
endmodule

// File: rtl/sg_checker.sv
// Property checker for status_guard, attached by bind. Observes ports only.
module sg_checker #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              wp_n,
    input logic              busy_i,
    input logic              wren_i,
    input logic [7:0]        status_o,
    input logic              stat_wr_ok_o,
    input logic              arr_wr_ok_o,
    input logic              arr_launch_o,
    input logic [ADDR_W-1:0] arr_addr_i
);
    a_r3_wel_rise_needs_wren: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[1]) |-> $past(wren_i));

    a_r2_busy_freezes_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !status_o[1]) |=> !status_o[1]);

    a_r5_lock_blocks_status: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && status_o[7]) |-> !stat_wr_ok_o);

    a_r7_full_blocks_array: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[3:2] == 2'b11) |-> !arr_wr_ok_o);

    a_r9_launch_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
        arr_launch_o |=> !status_o[1]);

    a_r4_cfg_only_after_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ({status_o[7], status_o[3:2]} != $past({status_o[7], status_o[3:2]}))
        |-> ($past(cs_n) && !$past(cs_n, 2)));
endmodule

bind status_guard sg_checker #(.ADDR_W(ADDR_W)) u_sg_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .wp_n         (wp_n),
    .busy_i       (busy_i),
    .wren_i       (wren_i),
    .status_o     (status_o),
    .stat_wr_ok_o (stat_wr_ok_o),
    .arr_wr_ok_o  (arr_wr_ok_o),
    .arr_launch_o (arr_launch_o),
    .arr_addr_i   (arr_addr_i)
);

// File: tb/status_guard_bench.sv
module status_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 14;
    localparam logic [AW-1:0] A_LOW = 14'h0100; // bottom quarter
    localparam logic [AW-1:0] A_Q3  = 14'h2100; // top half, not top quarter
    localparam logic [AW-1:0] A_TOP = 14'h3100; // top quarter

    typedef struct packed {
        logic          wren;
        logic          wrdi;
        logic          stwr;
        logic [7:0]    sdat;
        logic          cs_n;
        logic          wp_n;
        logic          busy;
        logic [AW-1:0] addr;
        logic          astart;
        logic [7:0]    e_stat;
        logic          e_arr;
        logic          e_st;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        //wren wrdi stwr sdat   cs wp bsy addr  st  status  arr  st  req
        '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b1,1'b0,A_LOW,1'b0,8'h00,1'b0,1'b0,4'd1}, // R1 idle
        '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,A_LOW,1'b0,8'h02,1'b1,1'b1,4'd3}, // R3 set
        '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b1,1'b0,A_LOW,1'b0,8'h02,1'b1,1'b1,4'd3},
        '{1'b0,1'b0,1'b1,8'hFF,1'b0,1'b1,1'b0,A_LOW,1'b0,8'h02,1'b1,1'b1,4'd4}, // R4 held
        '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b1,1'b0,A_LOW,1'b0,8'h8C,1'b0,1'b0,4'd4}, // R4 masked
        '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,A_LOW,1'b0,8'h8E,1'b0,1'b1,4'd7}, // R7 all
        '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,A_LOW,1'b0,8'h8E,1'b0,1'b0,4'd5}, // R5 lock
        '{1'b0,1'b0,1'b1,8'h00,1'b0,1'b0,1'b0,A_LOW,1'b0,8'h8E,1'b0,1'b0,4'd5},
        '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,A_LOW,1'b0,8'h8E,1'b0,1'b0,4'd5}, // R5 no change
        '{1'b0,1'b0,1'b1,8'h04,1'b0,1'b1,1'b0,A_LOW,1'b0,8'h8E,1'b0,1'b1,4'd5},
        '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b1,1'b0,A_LOW,1'b0,8'h04,1'b0,1'b0,4'd4},
        '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,A_TOP,1'b0,8'h06,1'b0,1'b1,4'd7}, // R7 quarter
        '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,A_Q3, 1'b1,8'h04,1'b0,1'b0,4'd3}, // R3 launch clr
        '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,A_TOP,1'b0,8'h06,1'b0,1'b1,4'd3},
        '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,A_TOP,1'b1,8'h06,1'b0,1'b1,4'd8}, // R8 blocked keeps
        '{1'b0,1'b1,1'b0,8'h00,1'b0,1'b1,1'b1,A_LOW,1'b0,8'h07,1'b0,1'b0,4'd2}, // R2 busy
        '{1'b0,1'b1,1'b0,8'h00,1'b0,1'b1,1'b0,A_TOP,1'b0,8'h04,1'b0,1'b0,4'd3},
        '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,A_TOP,1'b0,8'h06,1'b0,1'b1,4'd3},
        '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b1,1'b0,A_TOP,1'b0,8'h06,1'b0,1'b1,4'd3},
        '{1'b0,1'b0,1'b1,8'h80,1'b0,1'b1,1'b0,A_TOP,1'b0,8'h06,1'b0,1'b1,4'd4},
        '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b1,1'b0,A_TOP,1'b0,8'h80,1'b0,1'b0,4'd4},
        '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,A_TOP,1'b0,8'h82,1'b1,1'b1,4'd8},
        '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b1,1'b0,A_TOP,1'b0,8'h82,1'b1,1'b1,4'd8},
        '{1'b0,1'b0,1'b1,8'h88,1'b0,1'b1,1'b0,A_TOP,1'b0,8'h82,1'b1,1'b1,4'd6},
        '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,A_TOP,1'b0,8'h82,1'b1,1'b0,4'd6}, // R6 abort, R8 lock
        '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b1,1'b0,A_TOP,1'b0,8'h82,1'b1,1'b1,4'd6}, // R6 dropped
        '{1'b0,1'b0,1'b1,8'h84,1'b0,1'b1,1'b0,A_TOP,1'b0,8'h82,1'b1,1'b1,4'd6},
        '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,A_TOP,1'b0,8'h84,1'b0,1'b0,4'd6}  // R6 commit wins
    };

    logic clk = 1'b0;
    logic rst_n, cs_n, wp_n, busy, wren, wrdi, stwr, astart;
    logic [7:0] sdat;
    logic [AW-1:0] addr;
    logic [7:0] status;
    logic st_ok, arr_ok, launch;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    status_guard #(.ADDR_W(AW)) u_status_guard (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .busy_i(busy),
        .wren_i(wren), .wrdi_i(wrdi), .stat_wr_i(stwr), .stat_data_i(sdat),
        .arr_addr_i(addr), .arr_start_i(astart), .status_o(status),
        .stat_wr_ok_o(st_ok), .arr_wr_ok_o(arr_ok), .arr_launch_o(launch)
    );

    task automatic check(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic a_wren, input logic a_wrdi, input logic a_stwr,
                         input logic [7:0] a_sdat, input logic a_cs, input logic a_wp,
                         input logic a_busy, input logic [AW-1:0] a_addr, input logic a_st);
        wren = a_wren; wrdi = a_wrdi; stwr = a_stwr; sdat = a_sdat; cs_n = a_cs;
        wp_n = a_wp; busy = a_busy; addr = a_addr; astart = a_st;
    endtask

    // Apply at a falling edge, let one rising edge pass, return at the next falling edge.
    task automatic step(input logic a_wren, input logic a_wrdi, input logic a_stwr,
                        input logic [7:0] a_sdat, input logic a_cs, input logic a_wp,
                        input logic a_busy, input logic [AW-1:0] a_addr, input logic a_st);
        drive(a_wren, a_wrdi, a_stwr, a_sdat, a_cs, a_wp, a_busy, a_addr, a_st);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, A_LOW, 1'b0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check(1, "status after reset", status, 8'h00);
        check(1, "stat ok after reset", {7'd0, st_ok}, 8'h00);
        check(1, "arr ok after reset", {7'd0, arr_ok}, 8'h00);
        check(1, "launch after reset", {7'd0, launch}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].wren, VECS[i].wrdi, VECS[i].stwr, VECS[i].sdat, VECS[i].cs_n,
                 VECS[i].wp_n, VECS[i].busy, VECS[i].addr, VECS[i].astart);
            check(VECS[i].req, $sformatf("vec %0d status", i), status, VECS[i].e_stat);
            check(VECS[i].req, $sformatf("vec %0d arr ok", i), {7'd0, arr_ok}, {7'd0, VECS[i].e_arr});
            check(VECS[i].req, $sformatf("vec %0d stat ok", i), {7'd0, st_ok}, {7'd0, VECS[i].e_st});
        end

        // R1 mid-run reset clears the configuration (was 0x84)
        do_reset();
        check(1, "status after second reset", status, 8'h00);

        // R3 disable beats enable in the same cycle
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, A_LOW, 1'b0);
        check(3, "wren+wrdi", status, 8'h00);

        // R7 half protection: set level 10
        step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, A_LOW, 1'b0);
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, A_LOW, 1'b0);
        step(1'b0, 1'b0, 1'b1, 8'h08, 1'b0, 1'b1, 1'b0, A_LOW, 1'b0);
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, A_LOW, 1'b0);
        check(4, "half level set", status, 8'h08);
        step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, A_LOW, 1'b0);
        check(3, "wel set again", status, 8'h0A);
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, A_Q3, 1'b0);
        #1 check(7, "half blocks 0x2100", {7'd0, arr_ok}, 8'h00);
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 14'h1FFF, 1'b0);
        #1 check(7, "half allows 0x1FFF", {7'd0, arr_ok}, 8'h01);
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 14'h2000, 1'b0);
        #1 check(7, "half blocks 0x2000", {7'd0, arr_ok}, 8'h00);

        // R9 launch pulse seen before the edge, gone after it
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, A_LOW, 1'b1);
        #1 check(9, "launch granted", {7'd0, launch}, 8'h01);
        @(posedge clk);
        @(negedge clk);
        check(9, "launch drops after wel clear", {7'd0, launch}, 8'h00);
        check(3, "wel cleared by launch", status, 8'h08);
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, A_LOW, 1'b0);
        #1 check(2, "busy bit mirrors input", status, 8'h09);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule